// File: doc/BRIEF.md
# Thirteen-Level Switch-State Generator

This block produces the eleven gate commands of a single-source, thirteen-level switched-capacitor inverter. A phase accumulator, advanced by a tuning word on every enabled clock, addresses a quarter-wave sine table held as constants inside the block. The magnitude read from the table is scaled by a run-time modulation index. It is then compared against six triangular carriers that are stacked in equal amplitude bands. The number of carriers that the scaled magnitude exceeds is the level magnitude (0 to 6). The accumulator's top bit supplies the half-cycle sign.

The signed level selects one of fourteen fixed switch states. The two halves each have their own zero state, so a zero level keeps the switch pattern of the half cycle it falls in. Every gate that is about to turn on waits for a fixed number of clock cycles of dead time. A gate that is released turns off on the next clock. Deasserting the enable, or asserting reset, forces all gates low at once and restarts the phase and the carrier from zero.

With a 100 MHz clock, the default carrier band of 2500 steps gives a 5000-cycle triangle, which is 20 kHz. A 32-bit tuning word of 17180 gives about 400 Hz, and 42950 gives about 1 kHz.

Top module: `l13_gate_gen`

## Requirements
- R1: While `rst` is high or `en` is low, the next clock clears `level_o` to 0 and `half_o` to 0. It also clears the phase accumulator and the carrier, so a restarted run repeats the sequence of a fresh run.
- R2: On every enabled clock the accumulator adds `ftw_i` modulo 2^PHASE_W. After each enabled edge, `half_o` equals the accumulator's top bit as it was before that edge.
- R3: The sine magnitude is T[j] = floor(F*16*a*(D-a)/(5*D*D-4*a*(D-a))), where a=2j+1, D=4*2^QBITS and F=6*BAND. The index j is accumulator bits [PHASE_W-3 -: QBITS]. When bit PHASE_W-2 is 1, that index is mirrored to 2^QBITS-1-j.
- R4: The reference is floor(T*mi_i/2^MI_W).
- R5: The carrier value c starts at 0 and steps by 1 on every enabled clock, up to BAND and back down to 0, so its period is 2*BAND cycles. Carrier k (k=0..5) is k*BAND+c.
- R6: After each enabled edge, the magnitude of `level_o` is the number of carriers that the pre-edge reference strictly exceeds. `level_o` is two's complement: it is negative when `half_o` is 1 and the magnitude is nonzero, and it always lies in -6..+6.
- R7: `gate_o[10]` drives S1 and `gate_o[0]` drives S11. For positive-half levels 0 to 6 the target vectors, written S1..S11, are: 0 -> 01110011001, 1 -> 01010010101, 2 -> 11010010101, 3 -> 10111100100, 4 -> 01010100101, 5 -> 01110100101, 6 -> 10110100101.
- R8: For the negative half (`half_o`=1) the target vectors, written S1..S11, are: 0 -> 01101101010, -1 -> 01001101010, -2 -> 11001101010, -3 -> 10111011000, -4 -> 01001011010, -5 -> 01101011010, -6 -> 10101011010. A zero level uses the zero state of its own half.
- R9: After an enabled edge, a gate is 1 only if its target bit was 1 at that edge and at each of the DEAD edges before it, all of them enabled. This gives turn-on DEAD+1 cycles after the target rises, and turn-off one cycle after it falls.
- R10: `gate_o` is all zero in the same cycle that `rst` is high or `en` is low.
- R11: With `mi_i` at its maximum, a full fundamental period reaches |level| = 6. With `mi_i` at most 2^MI_W/4, |level| never exceeds 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces idle |
| ftw_i | input | PHASE_W | Fundamental frequency tuning word |
| mi_i | input | MI_W | Modulation index, full scale 2^MI_W |
| gate_o | output | 11 | Gate commands, bit 10 = S1 ... bit 0 = S11 |
| level_o | output | 4 | Current signed output level, -6..+6 |
| half_o | output | 1 | Half-cycle flag, 1 = negative half |

## Verification
The bench builds the block with PHASE_W=16, QBITS=4, BAND=20 and DEAD=3. With these values a fundamental period of about a thousand cycles spans roughly 25 carrier periods. A single run therefore visits all thirteen levels, both zero states and every dead-time window within a few thousand clocks. A behavioural model, built from the table formula, the triangle and the state list, predicts the level, the sign and all eleven gates on every clock. The run covers several tuning words and modulation indices, a disable gap and a mid-run reset.

// File: rtl/lvl13_pkg.sv
package lvl13_pkg;

    localparam int NSW   = 11;
    localparam int NBAND = 6;

    typedef logic [NSW-1:0] swvec_t;

    typedef struct packed {
        logic       neg;
        logic [2:0] mag;
    } lvl_t;

    // Rational sine approximation sampled at the centre of each quarter-wave slot
    function automatic int sine_quarter(int slot, int qdepth, int full);
        longint d;
        longint a;
        longint num;
        longint den;
        d   = 4 * longint'(qdepth);
        a   = 2 * longint'(slot) + 1;
        num = longint'(full) * 16 * a * (d - a);
        den = 5 * d * d - 4 * a * (d - a);
        return int'(num / den);
    endfunction

    // Fixed state list, bit 10 = S1 ... bit 0 = S11
    function automatic swvec_t state_vec(lvl_t l);
        swvec_t v;
        case ({l.neg, l.mag})
            4'b0_000: v = 11'b01110011001;
            4'b0_001: v = 11'b01010010101;
            4'b0_010: v = 11'b11010010101;
            4'b0_011: v = 11'b10111100100;
            4'b0_100: v = 11'b01010100101;
            4'b0_101: v = 11'b01110100101;
            4'b0_110: v = 11'b10110100101;
            4'b1_000: v = 11'b01101101010;
            4'b1_001: v = 11'b01001101010;
            4'b1_010: v = 11'b11001101010;
            4'b1_011: v = 11'b10111011000;
            4'b1_100: v = 11'b01001011010;
            4'b1_101: v = 11'b01101011010;
            4'b1_110: v = 11'b10101011010;
            default:  v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/l13_ref.sv
module l13_ref
    import lvl13_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int QBITS   = 6,
    parameter int FULL    = 15000,
    parameter int MI_W    = 8,
    localparam int QDEPTH  = 1 << QBITS,
    localparam int AMP_W   = $clog2(FULL + 1),
    localparam int IDX_LSB = PHASE_W - 2 - QBITS,
    localparam int PROD_W  = AMP_W + MI_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [PHASE_W-1:0] ftw_i,
    input  logic [MI_W-1:0]    mi_i,
    output logic               neg_o,
    output logic [AMP_W-1:0]   ref_o
);

    logic [PHASE_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || !en) phase <= '0;
        else            phase <= phase + ftw_i;
    end

    logic [AMP_W-1:0] qtab [QDEPTH];

    for (genvar g = 0; g < QDEPTH; g++) begin : g_tab
        assign qtab[g] = AMP_W'(sine_quarter(g, QDEPTH, FULL));
    end

    logic [QBITS-1:0] raw_idx;
    logic [QBITS-1:0] idx;
    logic [PROD_W-1:0] prod;
    logic unused_bits;

    assign raw_idx = phase[IDX_LSB +: QBITS];
    assign idx     = phase[PHASE_W-2] ? ~raw_idx : raw_idx;
    assign prod    = PROD_W'(qtab[idx]) * PROD_W'(mi_i);
    assign ref_o   = prod[PROD_W-1 -: AMP_W];
    assign neg_o   = phase[PHASE_W-1];
    assign unused_bits = ^{phase[IDX_LSB-1:0], prod[MI_W-1:0]};

endmodule

// File: rtl/l13_carrier.sv
module l13_carrier #(
    parameter int BAND = 2500,
    localparam int TW  = $clog2(BAND + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    output logic [TW-1:0] ramp_o
);

    logic rising;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ramp_o <= '0;
            rising <= 1'b1;
        end else if (rising) begin
            ramp_o <= ramp_o + 1'b1;
            if (ramp_o == TW'(BAND - 1)) rising <= 1'b0;
        end else begin
            ramp_o <= ramp_o - 1'b1;
            if (ramp_o == TW'(1)) rising <= 1'b1;
        end
    end

endmodule

// File: rtl/l13_deadtime.sv
module l13_deadtime #(
    parameter int N    = 11,
    parameter int DEAD = 50,
    localparam int CW  = $clog2(DEAD + 2)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [N-1:0] tgt_i,
    output logic [N-1:0] gate_o
);

    for (genvar b = 0; b < N; b++) begin : g_sw
        logic [CW-1:0] cnt;
        always_ff @(posedge clk) begin
            if (rst || !en || !tgt_i[b]) begin
                cnt       <= '0;
                gate_o[b] <= 1'b0;
            end else begin
                if (cnt != CW'(DEAD)) cnt <= cnt + 1'b1;
                gate_o[b] <= (cnt == CW'(DEAD));
            end
        end
    end

endmodule

// File: rtl/l13_gate_gen.sv
module l13_gate_gen
    import lvl13_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int QBITS   = 6,
    parameter int MI_W    = 8,
    parameter int BAND    = 2500,
    parameter int DEAD    = 50
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [PHASE_W-1:0] ftw_i,
    input  logic [MI_W-1:0]    mi_i,
    output logic [10:0]        gate_o,
    output logic signed [3:0]  level_o,
    output logic               half_o
);

    localparam int FULL  = NBAND * BAND;
    localparam int AMP_W = $clog2(FULL + 1);
    localparam int TW    = $clog2(BAND + 1);
    localparam int CMP_W = AMP_W + 1;

    logic             neg;
    logic [AMP_W-1:0] refmag;
    logic [TW-1:0]    ramp;

    l13_ref #(
        .PHASE_W(PHASE_W), .QBITS(QBITS), .FULL(FULL), .MI_W(MI_W)
    ) u_ref (
        .clk(clk), .rst(rst), .en(en), .ftw_i(ftw_i), .mi_i(mi_i),
        .neg_o(neg), .ref_o(refmag)
    );

    l13_carrier #(.BAND(BAND)) u_car (
        .clk(clk), .rst(rst), .en(en), .ramp_o(ramp)
    );

    logic [NBAND-1:0] above;

    for (genvar k = 0; k < NBAND; k++) begin : g_cmp
        assign above[k] = CMP_W'(refmag) > (CMP_W'(k * BAND) + CMP_W'(ramp));
    end

    lvl_t lvl_d;
    lvl_t lvl_q;

    always_comb begin
        lvl_d.neg = neg;
        lvl_d.mag = 3'($countones(above));
    end

    always_ff @(posedge clk) begin
        if (rst || !en) lvl_q <= '0;
        else            lvl_q <= lvl_d;
    end

    swvec_t tgt;
    swvec_t gate_q;

    assign tgt = state_vec(lvl_q);

    l13_deadtime #(.N(NSW), .DEAD(DEAD)) u_dt (
        .clk(clk), .rst(rst), .en(en), .tgt_i(tgt), .gate_o(gate_q)
    );

    assign gate_o  = (en && !rst) ? gate_q : '0;
    assign level_o = lvl_q.neg ? -$signed({1'b0, lvl_q.mag}) : $signed({1'b0, lvl_q.mag});
    assign half_o  = lvl_q.neg;

endmodule

// File: rtl/l13_gate_chk.sv
module l13_gate_chk
    import lvl13_pkg::*;
#(
    parameter int DEAD = 50,
    localparam int CW  = $clog2(DEAD + 2)
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic [10:0]       gate_o,
    input logic signed [3:0] level_o,
    input logic              half_o
);

    lvl_t   seen;
    swvec_t seen_vec;

    always_comb begin
        seen.neg = half_o;
        seen.mag = half_o ? 3'(-level_o) : 3'(level_o);
    end
    assign seen_vec = state_vec(seen);

    // R10: disabled means no gate is on
    p_off_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !en |-> gate_o == '0);

    // R1: a disabled cycle leaves an idle level and positive half
    p_idle_level_r1: assert property (@(posedge clk) disable iff (rst)
        $past(!en) |-> (level_o == 4'sd0 && !half_o));

    // R6: range and sign agreement
    p_level_sign_r6: assert property (@(posedge clk) disable iff (rst)
        (level_o >= -4'sd6) && (level_o <= 4'sd6) &&
        (half_o ? (level_o <= 4'sd0) : (level_o >= 4'sd0)));

    // R9: a gate may only be on if the previous state asked for it
    p_gate_subset_r9: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en)) |-> ((gate_o & ~$past(seen_vec)) == '0));

    for (genvar b = 0; b < 11; b++) begin : g_hold
        logic [CW-1:0] hold;
        always_ff @(posedge clk) begin
            if (rst || !en || !seen_vec[b]) hold <= '0;
            else if (hold != CW'(DEAD + 1)) hold <= hold + 1'b1;
        end
        // R9: turn-on only after the full dead-time window
        p_deadtime_r9: assert property (@(posedge clk) disable iff (rst)
            $rose(gate_o[b]) |-> hold == CW'(DEAD + 1));
    end

endmodule

bind l13_gate_gen l13_gate_chk #(.DEAD(DEAD)) u_chk (.*);

// File: tb/tb_l13_gate_gen.sv
`timescale 1ns/1ps
module tb_l13_gate_gen;

    localparam int PW   = 16;
    localparam int QB   = 4;
    localparam int MW   = 8;
    localparam int BAND = 20;
    localparam int DEAD = 3;
    localparam int FULL = 6 * BAND;

    logic clk = 1'b0;
    logic rst;
    logic en;
    logic [PW-1:0] ftw;
    logic [MW-1:0] mi;
    logic [10:0] gate_o;
    logic signed [3:0] level_o;
    logic half_o;

    always #5 clk = ~clk;

    l13_gate_gen #(.PHASE_W(PW), .QBITS(QB), .MI_W(MW), .BAND(BAND), .DEAD(DEAD)) dut (
        .clk(clk), .rst(rst), .en(en), .ftw_i(ftw), .mi_i(mi),
        .gate_o(gate_o), .level_o(level_o), .half_o(half_o)
    );

    int nchk = 0;
    int nerr = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    function automatic logic [10:0] vec_of(bit neg, int mag);
        logic [10:0] v;
        case ({neg, 3'(mag)})
            4'b0_000: v = 11'b01110011001;
            4'b0_001: v = 11'b01010010101;
            4'b0_010: v = 11'b11010010101;
            4'b0_011: v = 11'b10111100100;
            4'b0_100: v = 11'b01010100101;
            4'b0_101: v = 11'b01110100101;
            4'b0_110: v = 11'b10110100101;
            4'b1_000: v = 11'b01101101010;
            4'b1_001: v = 11'b01001101010;
            4'b1_010: v = 11'b11001101010;
            4'b1_011: v = 11'b10111011000;
            4'b1_100: v = 11'b01001011010;
            4'b1_101: v = 11'b01101011010;
            4'b1_110: v = 11'b10101011010;
            default:  v = '0;
        endcase
        return v;
    endfunction

    function automatic int tab_val(int j);
        longint d;
        longint a;
        d = 4 * (1 << QB);
        a = 2 * j + 1;
        return int'((longint'(FULL) * 16 * a * (d - a)) / (5 * d * d - 4 * a * (d - a)));
    endfunction

    // reference model state
    int m_ph = 0;
    int m_cc = 0;
    int m_mag = 0;
    bit m_neg = 0;
    logic [10:0] m_gate = '0;
    logic [10:0] hist[$];
    bit checking = 0;
    int max_abs = 0;
    bit seen_pz = 0;
    bit seen_nz = 0;

    always @(posedge clk) begin
        if (rst || !en) begin
            m_ph = 0; m_cc = 0; m_mag = 0; m_neg = 0;
            hist.delete();
            m_gate = '0;
        end else begin
            int j, r, c, cnt;
            logic [10:0] acc;
            hist.push_back(vec_of(m_neg, m_mag));
            if (hist.size() > DEAD + 1) void'(hist.pop_front());
            acc = '1;
            foreach (hist[i]) acc = acc & hist[i];
            m_gate = (hist.size() == DEAD + 1) ? acc : '0;
            j = (m_ph >> (PW - 2 - QB)) & ((1 << QB) - 1);
            if (((m_ph >> (PW - 2)) & 1) == 1) j = (1 << QB) - 1 - j;
            r = (tab_val(j) * int'(mi)) >> MW;
            c = (m_cc < BAND) ? m_cc : 2 * BAND - m_cc;
            cnt = 0;
            for (int k = 0; k < 6; k++) if (r > k * BAND + c) cnt++;
            m_mag = cnt;
            m_neg = ((m_ph >> (PW - 1)) & 1) == 1;
            m_ph = (m_ph + int'(ftw)) & ((1 << PW) - 1);
            m_cc = (m_cc + 1) % (2 * BAND);
        end
        #3;
        if (checking) begin
            int el;
            logic [10:0] eg;
            el = m_neg ? -m_mag : m_mag;
            eg = (en && !rst) ? m_gate : '0;
            chk(gate_o == eg, "R7 R8 R9 R10 gate vector", int'(gate_o), int'(eg));
            chk(int'(level_o) == el, "R3 R4 R5 R6 level", int'(level_o), el);
            chk(half_o == m_neg, "R2 half flag", int'(half_o), int'(m_neg));
            if ((level_o < 0 ? -level_o : level_o) > max_abs)
                max_abs = (level_o < 0) ? -int'(level_o) : int'(level_o);
            if (en && !rst && level_o == 0 && !half_o && gate_o == 11'b01110011001) seen_pz = 1;
            if (en && !rst && level_o == 0 && half_o && gate_o == 11'b01101101010) seen_nz = 1;
        end
    end

    initial begin
        #(10 * 150000);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        rst = 1'b1; en = 1'b1; ftw = 16'd64; mi = 8'd255;
        repeat (4) @(negedge clk);
        chk(gate_o == '0, "R10 gates during reset", int'(gate_o), 0);
        chk(level_o == 0, "R1 level during reset", int'(level_o), 0);
        chk(half_o == 1'b0, "R1 half during reset", int'(half_o), 0);
        checking = 1;
        rst = 1'b0;
        max_abs = 0;
        repeat (2200) @(negedge clk);
        chk(max_abs == 6, "R11 full index reaches level 6", max_abs, 6);
        chk(seen_pz, "R8 positive zero state seen", int'(seen_pz), 1);
        chk(seen_nz, "R8 negative zero state seen", int'(seen_nz), 1);

        mi = 8'd64;
        repeat (20) @(negedge clk);
        max_abs = 0;
        repeat (2100) @(negedge clk);
        chk(max_abs <= 2, "R11 quarter index caps level", max_abs, 2);
        chk(max_abs >= 1, "R11 quarter index still modulates", max_abs, 1);

        en = 1'b0;
        #1;
        chk(gate_o == '0, "R10 gates drop with enable", int'(gate_o), 0);
        @(negedge clk);
        chk(level_o == 0 && !half_o, "R1 idle after disable", int'(level_o), 0);
        repeat (5) @(negedge clk);
        en = 1'b1; ftw = 16'd200; mi = 8'd200;
        repeat (2000) @(negedge clk);

        rst = 1'b1;
        #1;
        chk(gate_o == '0, "R10 gates drop with reset", int'(gate_o), 0);
        repeat (3) @(negedge clk);
        rst = 1'b0; ftw = 16'd37; mi = 8'd255;
        repeat (1800) @(negedge clk);

        checking = 0;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule